// File: doc/BRIEF.md
# Batch-Parallel 8-Bit Tile Multiply-Accumulate Engine

This engine multiplies one square tile of signed 8-bit weights (or errors) by a square tile of signed 8-bit activations. It does this for every batch lane at once. Partial results build up in signed 32-bit accumulators across a series of commands, one command per reduction tile. The command that carries the last flag ends the series, and the engine then streams the result out one row per transfer. Three modes are available. Forward mode requantizes each sum to 8 bits. Backward mode outputs the full 32-bit sums. Gradient mode uses each activation tile transposed and adds the results of all batch lanes into one gradient tile, so the batch dimension is reduced inside the engine.

Operands are loaded one element at a time through two write ports: one for the shared weight tile and one for the per-lane activation tiles. A controller upstream sends a series of commands, which are accepted one at a time. The first command of a series sets the clear flag, so stale sums are discarded. The engine is controlled by a state machine with three states. IDLE goes to COMPUTE when a command is accepted. COMPUTE steps through one row per cycle and stays for TI cycles. At the final row it goes back to IDLE if the last flag was clear, or on to DRAIN if the last flag was set. DRAIN goes to IDLE on the handshake of the final result row.

Top module: `tmac_engine`

## Requirements
- R1: After reset `cmd_ready` is 1, `out_valid` is 0, and all accumulators and operand tiles are zero.
- R2: In forward mode (`cmd_mode` = 0), lane l row i column j accumulates the sum over k of W[i][k]·X_l[k][j], where W and X are signed 8-bit values.
- R3: A command without the last flag produces no output. `cmd_ready` stays low for exactly TI cycles after acceptance.
- R4: A command with `cmd_clear` = 1 replaces each accumulator with that tile's product instead of adding to the previous contents.
- R5: The forward output element is computed as follows: add 2^(s-1) when the shift s is not 0, shift right arithmetically by s, and saturate to −128..127. The result is sign-extended into its 32-bit column slot.
- R6: In backward mode (`cmd_mode` = 1, and also 3), each column slot carries the raw 32-bit signed accumulator.
- R7: In gradient mode (`cmd_mode` = 2), the product uses X_l[j][k], which is the transposed activation. Each output is the sum over all lanes. Only TI rows are emitted, and all of them carry `out_lane` = 0.
- R8: Rows are emitted ordered by lane first and then by ascending row. Column j sits at bits [32j+31:32j]. While `out_valid` is high and `out_ready` is low, the row, lane and data do not change.
- R9: `cmd_ready` is low from acceptance until the final result row has been taken. After that the engine returns to IDLE with `out_valid` low.
- R10: The weight element (i,k) is written at address i·TI+k. The activation element (r,c) of lane `act_lane` is written at address r·TI+c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_we | input | 1 | Weight element write strobe |
| wt_addr | input | log2(TI·TI) | Weight element address, row·TI+col |
| wt_data | input | 8 | Signed weight element |
| act_we | input | 1 | Activation element write strobe |
| act_lane | input | max(1,log2 TB) | Batch lane of the activation write |
| act_addr | input | log2(TI·TI) | Activation element address, row·TI+col |
| act_data | input | 8 | Signed activation element |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_mode | input | 2 | 0 forward, 1 or 3 backward, 2 gradient |
| cmd_clear | input | 1 | Overwrite accumulators with this tile's product |
| cmd_last | input | 1 | Final reduction tile; stream the result afterwards |
| cmd_shift | input | 5 | Forward requantization shift |
| out_valid | output | 1 | Result row available |
| out_ready | input | 1 | Consumer takes the row |
| out_lane | output | max(1,log2 TB) | Lane of the current row (0 in gradient mode) |
| out_row | output | log2 TI | Row index within the tile |
| out_data | output | 32·TI | Row of results, column j in slot j |

## Verification
The engine is driven with several kinds of operand patterns:
- An identity weight tile with indexed activations. This exposes any error in addressing or column placement, because each output must reproduce its input element exactly.
- Full-scale operands of both signs. These drive the accumulators far beyond 8 bits, so the saturation clamps and the rounding at large shifts are exercised.
- Small random operands with moderate shifts. These keep the results inside the 8-bit range, so the rounding is tested rather than the clamp.
- Full-range random operands in backward and gradient series that span several tiles. These separate a true running sum from a single-tile product, and a transposed per-lane reduction from a plain one.

The result stream is consumed with random backpressure, so the order in which rows are emitted and how they are held under a stall are checked together with the arithmetic.

// File: rtl/tmac_pkg.sv
package tmac_pkg;

    localparam logic [1:0] MODE_FWD  = 2'd0;
    localparam logic [1:0] MODE_BWD  = 2'd1;
    localparam logic [1:0] MODE_GRAD = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPUTE = 2'd1,
        ST_DRAIN   = 2'd2
    } tmac_state_e;

endpackage

// File: rtl/tmac_operand_store.sv
module tmac_operand_store #(
    parameter int TI = 4,
    parameter int TB = 2,
    parameter int DW = 8,
    localparam int AW = $clog2(TI * TI),
    localparam int LW = (TB > 1) ? $clog2(TB) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wt_we,
    input  logic [AW-1:0]           wt_addr,
    input  logic [DW-1:0]           wt_data,
    input  logic                    act_we,
    input  logic [LW-1:0]           act_lane,
    input  logic [AW-1:0]           act_addr,
    input  logic [DW-1:0]           act_data,
    output logic [TI*TI*DW-1:0]     wt_flat,
    output logic [TB*TI*TI*DW-1:0]  act_flat
);

    localparam int TILE = TI * TI;

    logic [DW-1:0] wt_mem  [TILE];
    logic [DW-1:0] act_mem [TB*TILE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < TILE; e++) wt_mem[e] <= '0;
        end else if (wt_we && (int'(wt_addr) < TILE)) begin
            wt_mem[wt_addr] <= wt_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < TB * TILE; e++) act_mem[e] <= '0;
        end else if (act_we && (int'(act_lane) < TB) && (int'(act_addr) < TILE)) begin
            act_mem[int'(act_lane) * TILE + int'(act_addr)] <= act_data;
        end
    end

    for (genvar e = 0; e < TILE; e++) begin : g_wt
        assign wt_flat[e*DW +: DW] = wt_mem[e];
    end

    for (genvar e = 0; e < TB * TILE; e++) begin : g_act
        assign act_flat[e*DW +: DW] = act_mem[e];
    end

endmodule

// File: rtl/tmac_row_mac.sv
module tmac_row_mac #(
    parameter int TI    = 4,
    parameter int TB    = 2,
    parameter int DW    = 8,
    parameter int ACC_W = 32,
    localparam int RW = $clog2(TI)
) (
    input  logic [RW-1:0]             row,
    input  logic                      transpose,
    input  logic [TI*TI*DW-1:0]       wt_flat,
    input  logic [TB*TI*TI*DW-1:0]    act_flat,
    output logic [TB*TI*ACC_W-1:0]    row_sum
);

    localparam int TILE = TI * TI;

    for (genvar l = 0; l < TB; l++) begin : g_lane
        for (genvar j = 0; j < TI; j++) begin : g_col
            logic signed [DW-1:0]    w_el;
            logic signed [DW-1:0]    x_el;
            logic signed [2*DW-1:0]  prod;
            logic signed [ACC_W-1:0] sum;
            int                      x_idx;

            always_comb begin
                sum   = '0;
                w_el  = '0;
                x_el  = '0;
                prod  = '0;
                x_idx = 0;
                for (int k = 0; k < TI; k++) begin
                    w_el  = wt_flat[(int'(row) * TI + k) * DW +: DW];
                    x_idx = transpose ? (l * TILE + j * TI + k) : (l * TILE + k * TI + j);
                    x_el  = act_flat[x_idx * DW +: DW];
                    prod  = w_el * x_el;
                    sum   = sum + ACC_W'(prod);
                end
            end

            assign row_sum[(l*TI + j)*ACC_W +: ACC_W] = sum;
        end
    end

endmodule

// File: rtl/tmac_requant.sv
module tmac_requant #(
    parameter int ACC_W = 32,
    parameter int DW    = 8,
    localparam int SH_W = $clog2(ACC_W)
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic [SH_W-1:0]         shift,
    output logic signed [DW-1:0]    q
);

    localparam logic signed [ACC_W:0] EXT_ONE = 1;
    localparam logic signed [ACC_W:0] QMAX    = (2 ** (DW - 1)) - 1;
    localparam logic signed [ACC_W:0] QMIN    = -(2 ** (DW - 1));

    logic signed [ACC_W:0] ext;
    logic signed [ACC_W:0] rnd;
    logic signed [ACC_W:0] sum;
    logic signed [ACC_W:0] shd;

    always_comb begin
        ext = {acc[ACC_W-1], acc};
        rnd = '0;
        if (shift != '0) rnd = EXT_ONE <<< (shift - SH_W'(1));
        sum = ext + rnd;
        shd = sum >>> shift;
        if (shd > QMAX)      q = QMAX[DW-1:0];
        else if (shd < QMIN) q = QMIN[DW-1:0];
        else                 q = shd[DW-1:0];
    end

endmodule

// File: rtl/tmac_engine.sv
module tmac_engine
    import tmac_pkg::*;
#(
    parameter int TI    = 4,
    parameter int TB    = 2,
    parameter int DW    = 8,
    parameter int ACC_W = 32,
    localparam int AW   = $clog2(TI * TI),
    localparam int LW   = (TB > 1) ? $clog2(TB) : 1,
    localparam int RW   = $clog2(TI),
    localparam int SH_W = $clog2(ACC_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wt_we,
    input  logic [AW-1:0]        wt_addr,
    input  logic [DW-1:0]        wt_data,
    input  logic                 act_we,
    input  logic [LW-1:0]        act_lane,
    input  logic [AW-1:0]        act_addr,
    input  logic [DW-1:0]        act_data,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [1:0]           cmd_mode,
    input  logic                 cmd_clear,
    input  logic                 cmd_last,
    input  logic [SH_W-1:0]      cmd_shift,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [LW-1:0]        out_lane,
    output logic [RW-1:0]        out_row,
    output logic [TI*ACC_W-1:0]  out_data
);

    localparam int TILE = TI * TI;

    tmac_state_e        state_q, state_d;
    logic [1:0]         mode_q;
    logic               clear_q;
    logic               last_q;
    logic [SH_W-1:0]    shift_q;
    logic [RW-1:0]      row_q;
    logic [LW-1:0]      lane_q;
    logic [ACC_W-1:0]   acc_q [TB*TILE];

    logic                   accept;
    logic                   row_end;
    logic                   lane_end;
    logic                   row_take;
    logic [TI*TI*DW-1:0]    wt_flat;
    logic [TB*TILE*DW-1:0]  act_flat;
    logic [TB*TI*ACC_W-1:0] row_sum;

    assign accept   = (state_q == ST_IDLE) && cmd_valid;
    assign row_end  = (row_q == RW'(TI - 1));
    assign lane_end = (mode_q == MODE_GRAD) || (lane_q == LW'(TB - 1));
    assign row_take = (state_q == ST_DRAIN) && out_ready;

    tmac_operand_store #(.TI(TI), .TB(TB), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wt_we    (wt_we),
        .wt_addr  (wt_addr),
        .wt_data  (wt_data),
        .act_we   (act_we),
        .act_lane (act_lane),
        .act_addr (act_addr),
        .act_data (act_data),
        .wt_flat  (wt_flat),
        .act_flat (act_flat)
    );

    tmac_row_mac #(.TI(TI), .TB(TB), .DW(DW), .ACC_W(ACC_W)) u_mac (
        .row       (row_q),
        .transpose (mode_q == MODE_GRAD),
        .wt_flat   (wt_flat),
        .act_flat  (act_flat),
        .row_sum   (row_sum)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_COMPUTE;
            end
            ST_COMPUTE: begin
                if (row_end) state_d = last_q ? ST_DRAIN : ST_IDLE;
            end
            ST_DRAIN: begin
                if (out_ready && row_end && lane_end) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command latch and row/lane counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_FWD;
            clear_q <= 1'b0;
            last_q  <= 1'b0;
            shift_q <= '0;
            row_q   <= '0;
            lane_q  <= '0;
        end else if (accept) begin
            mode_q  <= cmd_mode;
            clear_q <= cmd_clear;
            last_q  <= cmd_last;
            shift_q <= cmd_shift;
            row_q   <= '0;
            lane_q  <= '0;
        end else if (state_q == ST_COMPUTE) begin
            row_q <= row_end ? '0 : row_q + RW'(1);
        end else if (row_take) begin
            if (row_end) begin
                row_q  <= '0;
                lane_q <= lane_end ? '0 : lane_q + LW'(1);
            end else begin
                row_q <= row_q + RW'(1);
            end
        end
    end

    // accumulator array, one row of every lane per COMPUTE cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < TB * TILE; e++) acc_q[e] <= '0;
        end else if (state_q == ST_COMPUTE) begin
            for (int l = 0; l < TB; l++) begin
                for (int j = 0; j < TI; j++) begin
                    if (clear_q)
                        acc_q[(l*TI + int'(row_q))*TI + j] <= row_sum[(l*TI + j)*ACC_W +: ACC_W];
                    else
                        acc_q[(l*TI + int'(row_q))*TI + j] <= acc_q[(l*TI + int'(row_q))*TI + j]
                                                            + row_sum[(l*TI + j)*ACC_W +: ACC_W];
                end
            end
        end
    end

    // per-column result selection and requantization
    for (genvar j = 0; j < TI; j++) begin : g_col
        logic [ACC_W-1:0]     raw;
        logic signed [DW-1:0] q;

        always_comb begin
            raw = '0;
            if (mode_q == MODE_GRAD) begin
                for (int l = 0; l < TB; l++)
                    raw = raw + acc_q[(l*TI + int'(row_q))*TI + j];
            end else begin
                raw = acc_q[(int'(lane_q)*TI + int'(row_q))*TI + j];
            end
        end

        tmac_requant #(.ACC_W(ACC_W), .DW(DW)) u_rq (
            .acc   (raw),
            .shift (shift_q),
            .q     (q)
        );

        assign out_data[j*ACC_W +: ACC_W] = (mode_q == MODE_FWD)
                                          ? {{(ACC_W-DW){q[DW-1]}}, q}
                                          : raw;
    end

    // output flags
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        out_valid = (state_q == ST_DRAIN);
        out_row   = row_q;
        out_lane  = (mode_q == MODE_GRAD) ? '0 : lane_q;
    end

endmodule

// File: rtl/tmac_engine_chk.sv
module tmac_engine_chk #(
    parameter int TI    = 4,
    parameter int TB    = 2,
    parameter int DW    = 8,
    parameter int ACC_W = 32,
    parameter int LW    = 1,
    parameter int RW    = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [LW-1:0]      out_lane,
    input logic [RW-1:0]      out_row,
    input logic [TI*ACC_W-1:0] out_data,
    input logic [1:0]         mode_q
);

    function automatic logic fits_byte(input logic [TI*ACC_W-1:0] d);
        logic ok;
        logic signed [ACC_W-1:0] v;
        ok = 1'b1;
        for (int j = 0; j < TI; j++) begin
            v = d[j*ACC_W +: ACC_W];
            if (v > (2 ** (DW - 1)) - 1 || v < -(2 ** (DW - 1))) ok = 1'b0;
        end
        return ok;
    endfunction

    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !cmd_ready);

    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (!cmd_ready && !out_valid));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_row) && $stable(out_lane)));

    assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_row != RW'(TI - 1))
            |=> (out_valid && out_row == $past(out_row) + RW'(1) && out_lane == $past(out_lane)));

    assert_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_q == 2'd0) |-> fits_byte(out_data));

    assert_grad_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_q == 2'd2) |-> (out_lane == '0));

endmodule

bind tmac_engine tmac_engine_chk #(
    .TI(TI), .TB(TB), .DW(DW), .ACC_W(ACC_W), .LW(LW), .RW(RW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_lane  (out_lane),
    .out_row   (out_row),
    .out_data  (out_data),
    .mode_q    (mode_q)
);

// File: tb/tb_tmac_engine.sv
`timescale 1ns/1ps
module tb_tmac_engine;

    localparam int TI = 4;
    localparam int TB = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wt_we = 1'b0;
    logic [3:0]  wt_addr = '0;
    logic [7:0]  wt_data = '0;
    logic        act_we = 1'b0;
    logic [0:0]  act_lane = '0;
    logic [3:0]  act_addr = '0;
    logic [7:0]  act_data = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_mode = '0;
    logic        cmd_clear = 1'b0;
    logic        cmd_last = 1'b0;
    logic [4:0]  cmd_shift = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [0:0]  out_lane;
    logic [1:0]  out_row;
    logic [TI*32-1:0] out_data;

    always #4 clk = ~clk;

    tmac_engine #(.TI(TI), .TB(TB)) dut (.*);

    int W [TI][TI];
    int X [TB][TI][TI];
    int EA [TB][TI][TI];
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int bq(input int a, input int s);
        longint t;
        t = a;
        if (s > 0) t = (t + (longint'(1) << (s - 1))) >>> s;
        if (t > 127) t = 127;
        if (t < -128) t = -128;
        return int'(t);
    endfunction

    function automatic int rnd8(input int lo, input int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    // kind: 0 full random, 1 all +127, 2 W=-128 X=+127, 3 small random, 4 identity/indexed
    task automatic load(input int kind);
        for (int i = 0; i < TI; i++)
            for (int k = 0; k < TI; k++) begin
                case (kind)
                    0: W[i][k] = rnd8(-128, 127);
                    1: W[i][k] = 127;
                    2: W[i][k] = -128;
                    3: W[i][k] = rnd8(-8, 7);
                    default: W[i][k] = (i == k) ? 1 : 0;
                endcase
                @(negedge clk);
                wt_we = 1'b1; wt_addr = 4'(i * TI + k); wt_data = 8'(W[i][k]);
            end
        @(negedge clk); wt_we = 1'b0;
        for (int l = 0; l < TB; l++)
            for (int r = 0; r < TI; r++)
                for (int c = 0; c < TI; c++) begin
                    case (kind)
                        0: X[l][r][c] = rnd8(-128, 127);
                        1, 2: X[l][r][c] = 127;
                        3: X[l][r][c] = rnd8(-8, 7);
                        default: X[l][r][c] = (l == 0) ? (r * TI + c + 1) : -(r * TI + c + 1);
                    endcase
                    @(negedge clk);
                    act_we = 1'b1; act_lane = 1'(l); act_addr = 4'(r * TI + c);
                    act_data = 8'(X[l][r][c]);
                end
        @(negedge clk); act_we = 1'b0;
    endtask

    task automatic drain(input int mode, input int shift, input string tag);
        int nrows, idx, lane, row, v, got;
        bit rdy;
        nrows = (mode == 2) ? TI : TB * TI;
        idx = 0;
        while (idx < nrows) begin
            @(negedge clk);
            if (out_valid) begin
                rdy = ($urandom % 3) != 0;
                out_ready = rdy;
                if (rdy) begin
                    lane = (mode == 2) ? 0 : idx / TI;
                    row  = idx % TI;
                    chk(cmd_ready == 1'b0, "R9", "cmd_ready while draining", cmd_ready, 0);
                    chk(int'(out_lane) == lane && int'(out_row) == row, "R8",
                        "row order lane*16+row", int'(out_lane) * 16 + int'(out_row), lane * 16 + row);
                    for (int j = 0; j < TI; j++) begin
                        v = 0;
                        if (mode == 2) for (int l = 0; l < TB; l++) v += EA[l][row][j];
                        else v = EA[lane][row][j];
                        if (mode == 0) v = bq(v, shift);
                        got = $signed(out_data[j*32 +: 32]);
                        chk(got == v, tag, $sformatf("lane %0d row %0d col %0d", lane, row, j), got, v);
                    end
                    idx++;
                end
            end else begin
                out_ready = 1'b0;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk(cmd_ready == 1'b1 && out_valid == 1'b0, "R9", "idle after final row",
            {cmd_ready, out_valid}, 2);
    endtask

    task automatic issue(input int mode, input bit clear, input bit last, input int shift,
                         input string tag);
        int cnt;
        bit seen;
        for (int l = 0; l < TB; l++)
            for (int i = 0; i < TI; i++)
                for (int j = 0; j < TI; j++) begin
                    int p;
                    p = 0;
                    for (int k = 0; k < TI; k++)
                        p += W[i][k] * ((mode == 2) ? X[l][j][k] : X[l][k][j]);
                    EA[l][i][j] = clear ? p : EA[l][i][j] + p;
                end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = 2'(mode); cmd_clear = clear;
        cmd_last = last; cmd_shift = 5'(shift);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!last) begin
            cnt = 0; seen = 0;
            while (!cmd_ready && cnt < 100) begin
                if (out_valid) seen = 1;
                cnt++;
                @(negedge clk);
            end
            chk(cnt == TI && !seen, "R3", "busy cycles of non-last command", cnt, TI);
        end else begin
            drain(mode, shift, tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL all watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        // R1: accumulators zero -> backward, no clear, zero operands
        for (int l = 0; l < TB; l++) for (int i = 0; i < TI; i++) for (int j = 0; j < TI; j++) begin
            EA[l][i][j] = 0;
            X[l][i][j] = 0;
            W[i][j] = 0;
        end
        issue(1, 0, 1, 0, "R1");

        // R10 addressing: identity weights reproduce indexed activations
        load(4);
        issue(0, 1, 1, 0, "R10");

        // R2 forward with small operands
        load(3);
        issue(0, 1, 1, 2, "R2");

        // R6 backward accumulated over three tiles, R3 on the first two
        load(0); issue(1, 1, 0, 0, "R6");
        load(0); issue(1, 0, 0, 0, "R6");
        load(0); issue(1, 0, 1, 0, "R6");

        // R4 clear discards the stale sums above
        load(3);
        issue(0, 1, 1, 3, "R4");

        // R5 saturation and large-shift rounding
        load(1); issue(0, 1, 1, 0, "R5");
        load(2); issue(0, 1, 1, 0, "R5");
        load(1); issue(0, 1, 1, 10, "R5");
        load(3); issue(0, 1, 1, 1, "R5");

        // R7 gradient over two tiles
        load(0); issue(2, 1, 0, 0, "R7");
        load(0); issue(2, 0, 1, 0, "R7");

        // constrained random series
        for (int it = 0; it < 24; it++) begin
            int n, mode, sh;
            string tag;
            n = 1 + int'($urandom % 3);
            mode = int'($urandom % 3);
            sh = int'($urandom % 12);
            tag = (mode == 0) ? "R2" : (mode == 1) ? "R6" : "R7";
            for (int c = 0; c < n; c++) begin
                load(($urandom % 2) == 0 ? 0 : 3);
                issue(mode, c == 0, c == n - 1, sh, tag);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule